// File: doc/BRIEF.md
# Thermal ADC Auto-Monitor Controller

This block samples a temperature-sensor ADC on its own, one channel after another, and watches each result against two per-channel levels: an alarm level and a shutdown level. The converter reports a smaller code for a hotter die, so a channel counts as over a level when its code is strictly below that level. A channel has to stay over a level for a programmed number of back-to-back samples before anything happens. The alarm path then sets a pending bit that can raise an interrupt. The shutdown path latches a shutdown condition that drives a GPIO pin, a reset-controller pin, or both, at a programmable active level.

Software sets up the levels, debounce counts, polling periods and routing through a small synchronous register bus, then sets the run bit. The wait between two conversions is counted in ticks of a slow converter-clock enable. While any channel sits over either of its levels, the shorter hot period applies, so polling speeds up.

A conversion request is a valid/ready handshake. `conv_valid` rises with the channel number on `conv_chan`. Both hold steady while `conv_ready` is low, and the request is taken on the first cycle with both high. Only one request is outstanding at a time. The result comes back as a single-cycle `res_valid` pulse with `res_code`. The block always accepts it, so the result path has no back-pressure. The register read port is combinational on `bus_addr`. A write happens on any cycle with `bus_wen` high.

Top module: `thermo_poll_ctrl`

## Requirements
- R1: Register layout and reset values. Control at 0x00 has bit0 = run and bit1 = shutdown polarity. Enable at 0x04 has bits[2:0] = interrupt enable for channels 0-2, bits[10:8] = route a channel's shutdown to `shut_gpio`, and bits[18:16] = route it to `shut_rst`. Pending is at 0x08, bits[2:0]. Results are at 0x10+4·n, alarm levels at 0x20+4·n and shutdown levels at 0x30+4·n. Alarm debounce is at 0x40, shutdown debounce at 0x44, normal period at 0x48 and hot period at 0x4C. After reset every register reads 0, except both debounce counts (10), the normal period (1000) and the hot period (100). Unmapped addresses read 0. After reset `irq` = 0, `conv_valid` = 0 and both shutdown pins sit at the inactive level, which is 1 with polarity 0.
- R2: While run = 1, the block waits the current period in ticks after each result (or after run is set) and then raises a request. Requests visit channels 0, 1, 2 and then wrap. `conv_valid` and `conv_chan` hold until the cycle with `conv_ready` high.
- R3: The result register of a channel reads 0 until that channel's first result. After that it holds the 12-bit code of its latest result.
- R4: A sample is over a level only when its code is strictly less than that level. An equal code is not over.
- R5: The channel's pending bit is set on the sample that makes the alarm level exceeded on alarm-debounce consecutive samples (a count of 0 acts as 1). Any sample not over the level restarts the count.
- R6: Writing 1 to a pending bit clears it, and a new event in the same cycle wins over the clear. `irq` is high exactly when some pending bit has its enable bit set.
- R7: After shutdown-debounce consecutive samples under the shutdown level, the channel's shutdown latches. It drives each output pin whose route bit for that channel is set. It stays latched even when the temperature recovers, until run is cleared.
- R8: A shutdown pin is at level `polarity` while active and at the inverse level while inactive.
- R9: The hot period replaces the normal period while the latest sample of any channel is over its alarm or shutdown level. The normal period applies again once every channel's latest sample is under both levels.
- R10: Clearing run stops new requests from the next cycle on. A conversion already taken still completes and its result is stored. Clearing run also releases all latched shutdowns.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| tick | input | 1 | Slow converter-clock enable that paces the period counter |
| bus_wen | input | 1 | Register write strobe |
| bus_addr | input | 8 | Register byte address |
| bus_wdata | input | 32 | Register write data |
| bus_rdata | output | 32 | Read data for `bus_addr`, combinational |
| conv_valid | output | 1 | Conversion request valid |
| conv_ready | input | 1 | ADC accepts the request |
| conv_chan | output | 2 | Channel of the request |
| res_valid | input | 1 | Single-cycle result strobe |
| res_code | input | 12 | Conversion result |
| irq | output | 1 | Alarm interrupt |
| shut_gpio | output | 1 | Shutdown pin toward a GPIO |
| shut_rst | output | 1 | Shutdown pin toward the reset controller |

## Verification
A wrong scheduler state or period count shows first as `conv_valid` rising one or more cycles early or late, or with the wrong `conv_chan`. A reference model that follows the handshake catches that in the very cycle it happens. A corrupted debounce counter or hot flag is hidden until the next sample of that channel, and then it shows as an `irq` or shutdown-pin edge on the wrong sample, or as a request gap of the wrong length. The pending, result and routing registers are read back over the bus after each phase, so a wrong stored value appears at the port without waiting for a later event.

// File: rtl/thermo_pkg.sv
package thermo_pkg;
  typedef enum logic [1:0] {ST_IDLE, ST_WAIT, ST_REQ, ST_CONV} poll_st_t;

  // register byte offsets
  localparam logic [7:0] A_CTRL = 8'h00;
  localparam logic [7:0] A_ENAB = 8'h04;
  localparam logic [7:0] A_PEND = 8'h08;
  localparam logic [7:0] A_DATA = 8'h10;
  localparam logic [7:0] A_ALRM = 8'h20;
  localparam logic [7:0] A_SHUT = 8'h30;
  localparam logic [7:0] A_ADEB = 8'h40;
  localparam logic [7:0] A_SDEB = 8'h44;
  localparam logic [7:0] A_NPER = 8'h48;
  localparam logic [7:0] A_HPER = 8'h4C;

  // bit offsets of the routing fields inside the enable register
  localparam int ROUTE_GPIO_LSB = 8;
  localparam int ROUTE_RST_LSB  = 16;
endpackage

// File: rtl/thermo_poll_sched.sv
module thermo_poll_sched
  import thermo_pkg::*;
#(
  parameter int CH  = 3,
  parameter int PW  = 16,
  localparam int CHW = (CH > 1) ? $clog2(CH) : 1
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           run,
  input  logic           tick,
  input  logic [PW-1:0]  norm_per,
  input  logic [PW-1:0]  hot_per,
  input  logic           hot,
  output logic           conv_valid,
  input  logic           conv_ready,
  output logic [CHW-1:0] conv_chan,
  input  logic           res_valid,
  output logic           smp,
  output logic [CHW-1:0] smp_chan
);
  localparam logic [CHW-1:0] CH_LAST = CHW'(CH - 1);

  poll_st_t       st;
  logic [PW-1:0]  cnt;
  logic [CHW-1:0] ch;
  logic [PW-1:0]  per;
  logic           last;

  assign per  = hot ? hot_per : norm_per;
  assign last = ({1'b0, cnt} + 1'b1) >= {1'b0, per};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st  <= ST_IDLE;
      cnt <= '0;
      ch  <= '0;
    end else begin
      case (st)
        ST_IDLE: if (run) begin
          st  <= ST_WAIT;
          cnt <= '0;
        end
        ST_WAIT: begin
          if (!run) st <= ST_IDLE;
          else if (tick) begin
            if (last) begin
              st  <= ST_REQ;
              cnt <= '0;
            end else cnt <= cnt + 1'b1;
          end
        end
        ST_REQ: begin
          if (!run) st <= ST_IDLE;
          else if (conv_ready) st <= ST_CONV;
        end
        default: if (res_valid) begin
          st  <= run ? ST_WAIT : ST_IDLE;
          cnt <= '0;
          ch  <= (ch == CH_LAST) ? '0 : ch + 1'b1;
        end
      endcase
    end
  end

  assign conv_valid = (st == ST_REQ);
  assign conv_chan  = ch;
  assign smp        = (st == ST_CONV) && res_valid;
  assign smp_chan   = ch;

  // R2
  req_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (conv_valid && !conv_ready && run) |=> (conv_valid && $stable(conv_chan)));

  // R2
  chan_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
    conv_valid |-> (conv_chan <= CH_LAST));

  // R10
  stop_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !run |=> !conv_valid);
endmodule

// File: rtl/thermo_chan_mon.sv
module thermo_chan_mon #(
  parameter int DW  = 12,
  parameter int DBW = 8
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           smp,
  input  logic [DW-1:0]  code,
  input  logic [DW-1:0]  alarm_thr,
  input  logic [DW-1:0]  shut_thr,
  input  logic [DBW-1:0] alarm_deb,
  input  logic [DBW-1:0] shut_deb,
  input  logic           clr_shut,
  output logic [DW-1:0]  data,
  output logic           hot,
  output logic           alarm_evt,
  output logic           shut_on
);
  logic [DBW-1:0] acnt, scnt, a_next, s_next, a_need, s_need;
  logic           a_over, s_over, a_hot, s_hot, s_fire;

  // smaller code means hotter
  assign a_over = code < alarm_thr;
  assign s_over = code < shut_thr;
  assign a_next = a_over ? ((&acnt) ? acnt : acnt + 1'b1) : '0;
  assign s_next = s_over ? ((&scnt) ? scnt : scnt + 1'b1) : '0;
  assign a_need = (alarm_deb == '0) ? DBW'(1) : alarm_deb;
  assign s_need = (shut_deb == '0) ? DBW'(1) : shut_deb;

  assign alarm_evt = smp && a_over && (a_next >= a_need);
  assign s_fire    = smp && s_over && (s_next >= s_need);
  assign hot       = a_hot | s_hot;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      data    <= '0;
      acnt    <= '0;
      scnt    <= '0;
      a_hot   <= 1'b0;
      s_hot   <= 1'b0;
      shut_on <= 1'b0;
    end else begin
      if (smp) begin
        data  <= code;
        acnt  <= a_next;
        scnt  <= s_next;
        a_hot <= a_over;
        s_hot <= s_over;
      end
      if (clr_shut)    shut_on <= 1'b0;
      else if (s_fire) shut_on <= 1'b1;
    end
  end

  // R3
  data_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !smp |=> $stable(data));

  // R7
  shut_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (shut_on && !clr_shut) |=> shut_on);
endmodule

// File: rtl/thermo_poll_ctrl.sv
module thermo_poll_ctrl
  import thermo_pkg::*;
#(
  parameter int CH       = 3,
  parameter int DW       = 12,
  parameter int DBW      = 8,
  parameter int PW       = 16,
  parameter int AW       = 8,
  parameter int DEF_DEB  = 10,
  parameter int DEF_NPER = 1000,
  parameter int DEF_HPER = 100,
  localparam int CHW = (CH > 1) ? $clog2(CH) : 1
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           tick,
  input  logic           bus_wen,
  input  logic [AW-1:0]  bus_addr,
  input  logic [31:0]    bus_wdata,
  output logic [31:0]    bus_rdata,
  output logic           conv_valid,
  input  logic           conv_ready,
  output logic [CHW-1:0] conv_chan,
  input  logic           res_valid,
  input  logic [DW-1:0]  res_code,
  output logic           irq,
  output logic           shut_gpio,
  output logic           shut_rst
);
  logic           run, pol;
  logic [CH-1:0]  ien, rt_gpio, rt_rst, pend;
  logic [DW-1:0]  athr [CH];
  logic [DW-1:0]  sthr [CH];
  logic [DBW-1:0] adeb, sdeb;
  logic [PW-1:0]  nper, hper;

  logic [DW-1:0]  data_w [CH];
  logic [CH-1:0]  hot_w, evt_w, shut_w;
  logic           smp;
  logic [CHW-1:0] smp_chan;
  logic           pend_wr;
  logic           unused_wdata;

  assign unused_wdata = ^bus_wdata;
  assign pend_wr      = bus_wen && (bus_addr == AW'(A_PEND));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      run     <= 1'b0;
      pol     <= 1'b0;
      ien     <= '0;
      rt_gpio <= '0;
      rt_rst  <= '0;
      pend    <= '0;
      adeb    <= DBW'(DEF_DEB);
      sdeb    <= DBW'(DEF_DEB);
      nper    <= PW'(DEF_NPER);
      hper    <= PW'(DEF_HPER);
      for (int i = 0; i < CH; i++) begin
        athr[i] <= '0;
        sthr[i] <= '0;
      end
    end else begin
      pend <= (pend & ~(pend_wr ? bus_wdata[CH-1:0] : '0)) | evt_w;
      if (bus_wen) begin
        case (bus_addr)
          AW'(A_CTRL): begin
            run <= bus_wdata[0];
            pol <= bus_wdata[1];
          end
          AW'(A_ENAB): begin
            ien     <= bus_wdata[CH-1:0];
            rt_gpio <= bus_wdata[ROUTE_GPIO_LSB +: CH];
            rt_rst  <= bus_wdata[ROUTE_RST_LSB +: CH];
          end
          AW'(A_ADEB): adeb <= bus_wdata[DBW-1:0];
          AW'(A_SDEB): sdeb <= bus_wdata[DBW-1:0];
          AW'(A_NPER): nper <= bus_wdata[PW-1:0];
          AW'(A_HPER): hper <= bus_wdata[PW-1:0];
          default: ;
        endcase
        for (int i = 0; i < CH; i++) begin
          if (bus_addr == AW'(A_ALRM + 8'(4 * i))) athr[i] <= bus_wdata[DW-1:0];
          if (bus_addr == AW'(A_SHUT + 8'(4 * i))) sthr[i] <= bus_wdata[DW-1:0];
        end
      end
    end
  end

  always_comb begin
    bus_rdata = '0;
    case (bus_addr)
      AW'(A_CTRL): bus_rdata[1:0] = {pol, run};
      AW'(A_ENAB): begin
        bus_rdata[CH-1:0]              = ien;
        bus_rdata[ROUTE_GPIO_LSB +: CH] = rt_gpio;
        bus_rdata[ROUTE_RST_LSB +: CH]  = rt_rst;
      end
      AW'(A_PEND): bus_rdata[CH-1:0] = pend;
      AW'(A_ADEB): bus_rdata = 32'(adeb);
      AW'(A_SDEB): bus_rdata = 32'(sdeb);
      AW'(A_NPER): bus_rdata = 32'(nper);
      AW'(A_HPER): bus_rdata = 32'(hper);
      default: ;
    endcase
    for (int i = 0; i < CH; i++) begin
      if (bus_addr == AW'(A_DATA + 8'(4 * i))) bus_rdata = 32'(data_w[i]);
      if (bus_addr == AW'(A_ALRM + 8'(4 * i))) bus_rdata = 32'(athr[i]);
      if (bus_addr == AW'(A_SHUT + 8'(4 * i))) bus_rdata = 32'(sthr[i]);
    end
  end

  thermo_poll_sched #(.CH(CH), .PW(PW)) sched_i (
    .clk(clk), .rst_n(rst_n), .run(run), .tick(tick),
    .norm_per(nper), .hot_per(hper), .hot(|hot_w),
    .conv_valid(conv_valid), .conv_ready(conv_ready), .conv_chan(conv_chan),
    .res_valid(res_valid), .smp(smp), .smp_chan(smp_chan)
  );

  for (genvar g = 0; g < CH; g++) begin : g_chan
    thermo_chan_mon #(.DW(DW), .DBW(DBW)) mon_i (
      .clk(clk), .rst_n(rst_n),
      .smp(smp && (smp_chan == CHW'(g))), .code(res_code),
      .alarm_thr(athr[g]), .shut_thr(sthr[g]),
      .alarm_deb(adeb), .shut_deb(sdeb), .clr_shut(!run),
      .data(data_w[g]), .hot(hot_w[g]), .alarm_evt(evt_w[g]), .shut_on(shut_w[g])
    );
  end

  assign irq       = |(pend & ien);
  assign shut_gpio = (|(shut_w & rt_gpio)) ? pol : ~pol;
  assign shut_rst  = (|(shut_w & rt_rst)) ? pol : ~pol;

  // R6
  pend_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (pend_wr && (evt_w == '0)) |=> ((pend & $past(bus_wdata[CH-1:0])) == '0));
endmodule

// File: tb/thermo_poll_ctrl_tb.sv
module thermo_poll_ctrl_tb_top;
  localparam int CH = 3;

  logic        clk = 1'b0, rst_n = 1'b0, tick = 1'b0, bus_wen = 1'b0;
  logic [7:0]  bus_addr = '0;
  logic [31:0] bus_wdata = '0;
  wire  [31:0] bus_rdata;
  wire         conv_valid;
  logic        conv_ready = 1'b0;
  wire  [1:0]  conv_chan;
  logic        res_valid = 1'b0;
  logic [11:0] res_code = '0;
  wire         irq, shut_gpio, shut_rst;

  int checks = 0, errors = 0;
  bit done = 0;

  always #4ns clk = ~clk;

  thermo_poll_ctrl dut_i (
    .clk(clk), .rst_n(rst_n), .tick(tick), .bus_wen(bus_wen), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .conv_valid(conv_valid),
    .conv_ready(conv_ready), .conv_chan(conv_chan), .res_valid(res_valid),
    .res_code(res_code), .irq(irq), .shut_gpio(shut_gpio), .shut_rst(shut_rst)
  );

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  // ---------------- behavioural reference model ----------------
  int m_st, m_cnt, m_ch, m_run, m_pol, m_ien, m_rg, m_rr, m_pend;
  int m_adeb, m_sdeb, m_nper, m_hper;
  int m_ath[CH], m_sth[CH], m_data[CH], m_ac[CH], m_sc[CH];
  bit m_ah[CH], m_sh[CH], m_sl[CH];

  always @(posedge clk) begin
    int per, c, code, evt, clr, need;
    bit hotany, smp, ao, so, fire;
    if (!rst_n) begin
      m_st = 0; m_cnt = 0; m_ch = 0; m_run = 0; m_pol = 0; m_ien = 0; m_rg = 0; m_rr = 0;
      m_pend = 0; m_adeb = 10; m_sdeb = 10; m_nper = 1000; m_hper = 100;
      for (int k = 0; k < CH; k++) begin
        m_ath[k] = 0; m_sth[k] = 0; m_data[k] = 0; m_ac[k] = 0; m_sc[k] = 0;
        m_ah[k] = 0; m_sh[k] = 0; m_sl[k] = 0;
      end
    end else begin
      hotany = 0;
      for (int k = 0; k < CH; k++) if (m_ah[k] || m_sh[k]) hotany = 1;
      per = hotany ? m_hper : m_nper;
      smp = (m_st == 3) && res_valid;
      c = m_ch;
      evt = 0; fire = 0;
      case (m_st)
        0: if (m_run != 0) begin m_st = 1; m_cnt = 0; end
        1: if (m_run == 0) m_st = 0;
           else if (tick) begin
             if (m_cnt + 1 >= per) begin m_st = 2; m_cnt = 0; end
             else m_cnt++;
           end
        2: if (m_run == 0) m_st = 0; else if (conv_ready) m_st = 3;
        default: if (res_valid) begin
          m_st = (m_run != 0) ? 1 : 0; m_cnt = 0; m_ch = (m_ch + 1) % CH;
        end
      endcase
      if (smp) begin
        code = int'(res_code);
        ao = code < m_ath[c];
        so = code < m_sth[c];
        m_ac[c] = ao ? ((m_ac[c] < 255) ? m_ac[c] + 1 : 255) : 0;
        m_sc[c] = so ? ((m_sc[c] < 255) ? m_sc[c] + 1 : 255) : 0;
        need = (m_adeb == 0) ? 1 : m_adeb;
        if (ao && m_ac[c] >= need) evt = 1 << c;
        need = (m_sdeb == 0) ? 1 : m_sdeb;
        fire = so && (m_sc[c] >= need);
        m_data[c] = code; m_ah[c] = ao; m_sh[c] = so;
      end
      for (int k = 0; k < CH; k++) begin
        if (m_run == 0) m_sl[k] = 0;
        else if (smp && k == c && fire) m_sl[k] = 1;
      end
      clr = (bus_wen && bus_addr == 8'h08) ? int'(bus_wdata[2:0]) : 0;
      m_pend = ((m_pend & ~clr) | evt) & 7;
      if (bus_wen) begin
        case (bus_addr)
          8'h00: begin m_run = bus_wdata[0]; m_pol = bus_wdata[1]; end
          8'h04: begin
            m_ien = bus_wdata[2:0]; m_rg = bus_wdata[10:8]; m_rr = bus_wdata[18:16];
          end
          8'h40: m_adeb = bus_wdata[7:0];
          8'h44: m_sdeb = bus_wdata[7:0];
          8'h48: m_nper = bus_wdata[15:0];
          8'h4C: m_hper = bus_wdata[15:0];
          default: ;
        endcase
        for (int k = 0; k < CH; k++) begin
          if (bus_addr == 8'(8'h20 + 4 * k)) m_ath[k] = bus_wdata[11:0];
          if (bus_addr == 8'(8'h30 + 4 * k)) m_sth[k] = bus_wdata[11:0];
        end
      end
    end
  end

  function automatic logic [31:0] exp_rd(input logic [7:0] a);
    case (a)
      8'h04: return 32'(m_ien | (m_rg << 8) | (m_rr << 16));
      8'h08: return 32'(m_pend);
      8'h10: return 32'(m_data[0]);
      8'h14: return 32'(m_data[1]);
      8'h18: return 32'(m_data[2]);
      default: return 32'h0;
    endcase
  endfunction

  // per-cycle comparison of every output against the model
  always @(negedge clk) begin
    bit ag, ar;
    if (rst_n && !done) begin
      check("R2 R9 conv_valid timing", conv_valid, 32'(m_st == 2));
      if (m_st == 2) check("R2 conv_chan order", conv_chan, 32'(m_ch));
      check("R6 irq", irq, 32'((m_pend & m_ien) != 0));
      ag = 0; ar = 0;
      for (int k = 0; k < CH; k++) begin
        if (m_sl[k] && m_rg[k]) ag = 1;
        if (m_sl[k] && m_rr[k]) ar = 1;
      end
      check("R7 R8 shut_gpio", shut_gpio, 32'(ag ? m_pol[0] : !m_pol[0]));
      check("R7 R8 shut_rst", shut_rst, 32'(ar ? m_pol[0] : !m_pol[0]));
    end
  end

  // ---------------- tick and ADC model ----------------
  logic [11:0] adc_code[CH];
  bit tog2 = 0;
  int lat = 0, rcyc = 0, req_ch = 0;

  always @(negedge clk) begin
    if (!rst_n) begin
      tick = 0; conv_ready = 0; res_valid = 0; lat = 0;
    end else begin
      tick = ~tick;
      rcyc++;
      conv_ready = (rcyc % 3) != 0;
      res_valid = 0;
      if (lat > 0) begin
        lat--;
        if (lat == 0) begin
          res_valid = 1;
          res_code = adc_code[req_ch];
          if (tog2 && req_ch == 2) adc_code[2] = (adc_code[2] == 12'h300) ? 12'hC00 : 12'h300;
        end
      end else if (conv_valid && conv_ready) begin
        lat = 3; req_ch = int'(conv_chan);
      end
    end
  end

  // ---------------- bus tasks ----------------
  task automatic wr(input logic [7:0] a, input logic [31:0] d);
    @(negedge clk); bus_wen = 1; bus_addr = a; bus_wdata = d;
    @(negedge clk); bus_wen = 0;
  endtask

  task automatic rd_fix(input logic [7:0] a, input logic [31:0] exp, input string tag);
    @(negedge clk); bus_addr = a; #1ns;
    check(tag, bus_rdata, exp);
  endtask

  task automatic rd_mdl(input logic [7:0] a, input string tag);
    @(negedge clk); bus_addr = a; #1ns;
    check(tag, bus_rdata, exp_rd(a));
  endtask

  initial begin
    int reqs;
    adc_code[0] = 12'hC00; adc_code[1] = 12'hC00; adc_code[2] = 12'hC00;
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    // R1 reset state and layout
    check("R1 irq after reset", irq, 0);
    check("R1 conv_valid after reset", conv_valid, 0);
    check("R1 shut_gpio idle", shut_gpio, 1);
    check("R1 shut_rst idle", shut_rst, 1);
    rd_fix(8'h00, 0, "R1 control");
    rd_fix(8'h04, 0, "R1 enable");
    rd_fix(8'h08, 0, "R1 pending");
    rd_fix(8'h40, 10, "R1 alarm debounce");
    rd_fix(8'h44, 10, "R1 shutdown debounce");
    rd_fix(8'h48, 1000, "R1 normal period");
    rd_fix(8'h4C, 100, "R1 hot period");
    rd_fix(8'h5C, 0, "R1 unmapped");
    // R3 results read 0 before any conversion
    rd_fix(8'h10, 0, "R3 ch0 empty");
    rd_fix(8'h18, 0, "R3 ch2 empty");

    wr(8'h48, 6); wr(8'h4C, 2); wr(8'h40, 2); wr(8'h44, 3);
    wr(8'h20, 12'h100); wr(8'h30, 12'h080);
    wr(8'h24, 12'h800); wr(8'h34, 12'h400);
    wr(8'h28, 12'h800); wr(8'h38, 12'h400);
    wr(8'h04, 32'h0004_0207);
    rd_fix(8'h24, 12'h800, "R1 alarm level readback");
    rd_mdl(8'h04, "R1 enable readback");
    wr(8'h00, 1);
    repeat (250) @(negedge clk);
    rd_fix(8'h10, 12'hC00, "R3 ch0 result");
    rd_fix(8'h14, 12'hC00, "R3 ch1 result");
    rd_fix(8'h18, 12'hC00, "R3 ch2 result");
    rd_fix(8'h08, 0, "R5 no alarm when cool");

    // R4 equal code is not over
    adc_code[1] = 12'h800;
    repeat (250) @(negedge clk);
    rd_fix(8'h08, 0, "R4 equal code not over");
    check("R4 irq stays low", irq, 0);

    // R5 one below the level, held
    adc_code[1] = 12'h7FF;
    repeat (250) @(negedge clk);
    rd_fix(8'h08, 2, "R5 pending after debounce");
    check("R6 irq raised", irq, 1);

    // R6 write-one-to-clear after recovery
    adc_code[1] = 12'hC00;
    repeat (250) @(negedge clk);
    wr(8'h08, 2);
    rd_fix(8'h08, 0, "R6 pending cleared");
    check("R6 irq after clear", irq, 0);

    // R6 masked interrupt
    wr(8'h04, 32'h0004_0205);
    adc_code[1] = 12'h7FF;
    repeat (250) @(negedge clk);
    rd_fix(8'h08, 2, "R6 pending while masked");
    check("R6 masked irq low", irq, 0);
    adc_code[1] = 12'hC00;
    repeat (200) @(negedge clk);
    wr(8'h08, 7);
    wr(8'h04, 32'h0004_0207);

    // R5 alternating samples never complete the debounce
    adc_code[2] = 12'h300; tog2 = 1;
    repeat (500) @(negedge clk);
    rd_fix(8'h08, 0, "R5 alternating resets count");
    check("R7 no shutdown when alternating", shut_rst, 1);
    tog2 = 0;

    // R7 steady shutdown on channel 2, routed to reset pin only
    adc_code[2] = 12'h300;
    repeat (300) @(negedge clk);
    check("R7 shut_rst active low", shut_rst, 0);
    check("R7 shut_gpio not routed", shut_gpio, 1);
    rd_mdl(8'h08, "R5 pending on ch2");
    adc_code[2] = 12'hC00;
    repeat (250) @(negedge clk);
    check("R7 shutdown sticky", shut_rst, 0);

    // R8 polarity flip
    wr(8'h00, 3);
    check("R8 active high", shut_rst, 1);
    check("R8 gpio idle low", shut_gpio, 0);

    // R10 stop
    wr(8'h00, 2);
    @(negedge clk);
    check("R10 shutdown released", shut_rst, 0);
    reqs = 0;
    for (int i = 0; i < 150; i++) begin
      @(negedge clk);
      if (conv_valid) reqs++;
    end
    check("R10 no requests after stop", reqs, 0);
    rd_mdl(8'h18, "R3 ch2 last result");

    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      done = 1;
      checks++; errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule